// File: doc/BRIEF.md
# Pixel-Clock PLL Bring-Up Sequencer

This block changes the setting of a pixel-clock PLL without glitching the clock it feeds. A start pulse samples the active width and height of the requested display mode and looks them up in a fixed table of thirteen resolutions. The matching pair of 32-bit settings words comes out of the table. When no entry matches exactly, the 25 MHz setting is used. The upper settings word is loaded at once. The lower word, which is the PLL control word, is then rewritten in a fixed six-step order that moves two bypass levels and a power-on bit. There is a settling wait between the later steps.

The control word has three control bits at fixed positions: the outer bypass at bit 19, the inner bypass at bit 18 and power-on at bit 17. The settling wait is the parameter `WAIT_CYC`, counted in reference-clock cycles. Its default gives about 1 ms at 125 MHz, and a bench can make it short. The analog PLL is represented only by the words this block drives.

Top module: `pll_bringup_seq`

## Requirements
- R1: During and right after reset, `pllCtl` is 32'h0008_0119, `pllHi` is 32'hA500_0019, and `busy` and `done` are low.
- R2: A `startReq` that the clock samples while idle does two things at that edge E0. It loads `pllHi` with the selected upper word, and `busy` is high from the next cycle. `pllCtl` does not change at E0.
- R3: At E0+1, `pllCtl` becomes its previous value with only bit 19 (the outer bypass) cleared.
- R4: At E0+2, `pllCtl` becomes 32'h0006_0000: only the inner-bypass bit 18 and the power-on bit 17 are set.
- R5: At E0+3, `pllCtl` becomes the selected lower configuration word.
- R6: At E0+3+WAIT_CYC, bit 17 (power-on) of `pllCtl` is cleared. All other bits are kept.
- R7: At E0+3+2·WAIT_CYC, bit 18 (inner bypass) is cleared. All other bits are kept.
- R8: At E0+3+3·WAIT_CYC, bit 19 (outer bypass) is set. At the same edge `busy` falls and `done` goes high for exactly one cycle.
- R9: The table is matched exactly on width and height. The lower word is 32'h0006_0000 | (N<<8) | M and the upper word is 32'hA500_0000 | (M/N). The modes are 640x480 (M=25), 800x600 (40), 1024x768 (65), 1152x864 (M=160, N=2), 1280x768 (80), 1280x720 (74), 1280x960 (108), 1280x1024 (108), 1440x900 (106), 1600x900 (108), 1600x1200 (162), 1920x1080 (148) and 1920x1200 (193). N is 1 unless given.
- R10: A width and height pair that is not in the table selects M=25, N=1.
- R11: A `startReq` while `busy` is high is ignored. The sequence, its timing and `pllHi` are unchanged.
- R12: `ctlWrStb` is high in exactly the cycles that follow a step's write to `pllCtl`. Between writes, `pllCtl` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to start a reprogramming sequence |
| hActive | input | DIM_W | Active width of the requested mode |
| vActive | input | DIM_W | Active height of the requested mode |
| pllCtl | output | 32 | PLL control (lower settings) word |
| pllHi | output | 32 | PLL upper settings word |
| ctlWrStb | output | 1 | High in the cycle after each write of `pllCtl` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the final step is written |

## Verification
Every result is timed from the start edge E0, when `startReq` is sampled. `pllHi` and `busy` are due one cycle after E0. The three back-to-back control writes are due at E0+1, E0+2 and E0+3. The three delayed writes land at E0+3 plus one, two and three times `WAIT_CYC`, with `done` beside the last of them. The bench drives on falling edges and samples every falling edge of the sequence. This checks each step in the exact cycle it is due, and checks that the word holds steady in every cycle between steps. The bench sweeps all table modes and several pairs that miss the table. It also makes one run with a second request injected mid-wait.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int OUTER_BIT = 19;
  localparam int INNER_BIT = 18;
  localparam int PWR_BIT   = 17;

  localparam logic [31:0] OUTER_MASK = 32'(1) << OUTER_BIT;
  localparam logic [31:0] INNER_MASK = 32'(1) << INNER_BIT;
  localparam logic [31:0] PWR_MASK   = 32'(1) << PWR_BIT;
  localparam logic [31:0] ARM_WORD   = INNER_MASK | PWR_MASK;
  localparam logic [31:0] HI_BASE    = 32'hA500_0000;

  localparam int NUM_MODES = 13;
  localparam int unsigned MODE_H [NUM_MODES] =
    '{640, 800, 1024, 1152, 1280, 1280, 1280, 1280, 1440, 1600, 1600, 1920, 1920};
  localparam int unsigned MODE_V [NUM_MODES] =
    '{480, 600, 768, 864, 768, 720, 960, 1024, 900, 900, 1200, 1080, 1200};
  localparam int unsigned MODE_M [NUM_MODES] =
    '{25, 40, 65, 160, 80, 74, 108, 108, 106, 108, 162, 148, 193};
  localparam int unsigned MODE_N [NUM_MODES] =
    '{1, 1, 1, 2, 1, 1, 1, 1, 1, 1, 1, 1, 1};

  localparam int unsigned DEF_M = 25;
  localparam int unsigned DEF_N = 1;

  localparam logic [31:0] DEF_LO = ARM_WORD | (32'(DEF_N) << 8) | 32'(DEF_M);
  localparam logic [31:0] RST_CTL = (DEF_LO & ~ARM_WORD) | OUTER_MASK;
  localparam logic [31:0] RST_HI  = HI_BASE | 32'(DEF_M / DEF_N);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLR_OUT, ST_ARM, ST_LOAD, ST_WAIT_PWR, ST_WAIT_INNER, ST_WAIT_OUTER
  } seqState_t;

  typedef struct packed {
    logic latchCfg;
    logic clrOuter;
    logic loadArm;
    logic loadCfg;
    logic clrPwr;
    logic clrInner;
    logic setOuter;
  } seqStrobe_t;

endpackage

// File: rtl/pll_mode_lut.sv
module pll_mode_lut
  import pllseq_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic [DIM_W-1:0] hActive,
  input  logic [DIM_W-1:0] vActive,
  output logic [31:0]      cfgLo,
  output logic [31:0]      cfgHi
);

  logic       hit;
  logic [7:0] mVal;
  logic [7:0] nVal;
  logic [7:0] fVal;

  always_comb begin
    hit  = 1'b0;
    mVal = 8'(DEF_M);
    nVal = 8'(DEF_N);
    fVal = 8'(DEF_M / DEF_N);
    for (int i = 0; i < NUM_MODES; i++) begin
      if (!hit && 32'(hActive) == MODE_H[i] && 32'(vActive) == MODE_V[i]) begin
        hit  = 1'b1;
        mVal = 8'(MODE_M[i]);
        nVal = 8'(MODE_N[i]);
        fVal = 8'(MODE_M[i] / MODE_N[i]);
      end
    end
    cfgLo = ARM_WORD | {16'd0, nVal, mVal};
    cfgHi = HI_BASE | {24'd0, fVal};
  end

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pllseq_pkg::*;
#(
  parameter int WAIT_CYC = 125000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYC - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             cntZero;

  assign cntZero = (cnt == '0);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE:    if (startReq) state <= ST_CLR_OUT;
        ST_CLR_OUT: state <= ST_ARM;
        ST_ARM:     state <= ST_LOAD;
        ST_LOAD: begin
          state <= ST_WAIT_PWR;
          cnt   <= RELOAD;
        end
        ST_WAIT_PWR: begin
          if (cntZero) begin
            state <= ST_WAIT_INNER;
            cnt   <= RELOAD;
          end else cnt <= cnt - 1'b1;
        end
        ST_WAIT_INNER: begin
          if (cntZero) begin
            state <= ST_WAIT_OUTER;
            cnt   <= RELOAD;
          end else cnt <= cnt - 1'b1;
        end
        ST_WAIT_OUTER: begin
          if (cntZero) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.latchCfg = (state == ST_IDLE) && startReq;
    strb.clrOuter = (state == ST_CLR_OUT);
    strb.loadArm  = (state == ST_ARM);
    strb.loadCfg  = (state == ST_LOAD);
    strb.clrPwr   = (state == ST_WAIT_PWR) && cntZero;
    strb.clrInner = (state == ST_WAIT_INNER) && cntZero;
    strb.setOuter = (state == ST_WAIT_OUTER) && cntZero;
  end

endmodule

// File: rtl/pll_seq_datapath.sv
module pll_seq_datapath
  import pllseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  strb,
  input  logic [31:0] cfgLo,
  input  logic [31:0] cfgHi,
  output logic [31:0] pllCtl,
  output logic [31:0] pllHi,
  output logic        ctlWrStb
);

  logic [31:0] cfgLoQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLoQ   <= DEF_LO;
      pllHi    <= RST_HI;
      pllCtl   <= RST_CTL;
      ctlWrStb <= 1'b0;
    end else begin
      if (strb.latchCfg) begin
        cfgLoQ <= cfgLo;
        pllHi  <= cfgHi;
      end
      if (strb.clrOuter)      pllCtl <= pllCtl & ~OUTER_MASK;
      else if (strb.loadArm)  pllCtl <= ARM_WORD;
      else if (strb.loadCfg)  pllCtl <= cfgLoQ;
      else if (strb.clrPwr)   pllCtl <= pllCtl & ~PWR_MASK;
      else if (strb.clrInner) pllCtl <= pllCtl & ~INNER_MASK;
      else if (strb.setOuter) pllCtl <= pllCtl | OUTER_MASK;
      ctlWrStb <= strb.clrOuter | strb.loadArm | strb.loadCfg |
                  strb.clrPwr | strb.clrInner | strb.setOuter;
    end
  end

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pllseq_pkg::*;
#(
  parameter int DIM_W    = 12,
  parameter int WAIT_CYC = 125000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIM_W-1:0] hActive,
  input  logic [DIM_W-1:0] vActive,
  output logic [31:0]      pllCtl,
  output logic [31:0]      pllHi,
  output logic             ctlWrStb,
  output logic             busy,
  output logic             done
);

  seqStrobe_t  strb;
  logic [31:0] cfgLo;
  logic [31:0] cfgHi;

  pll_mode_lut #(.DIM_W(DIM_W)) u_lut (
    .hActive(hActive), .vActive(vActive), .cfgLo(cfgLo), .cfgHi(cfgHi)
  );

  pll_seq_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .strb(strb), .busy(busy), .done(done)
  );

  pll_seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgLo(cfgLo), .cfgHi(cfgHi),
    .pllCtl(pllCtl), .pllHi(pllHi), .ctlWrStb(ctlWrStb)
  );

endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startReq,
  input logic [31:0] pllCtl,
  input logic [31:0] pllHi,
  input logic        ctlWrStb,
  input logic        busy,
  input logic        done
);

  // R2: an idle start is always taken
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy) else $error("a_r2_start_sets_busy");

  // R3: outer bypass stays off for the whole body of a sequence
  a_r3_outer_off_in_seq: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !pllCtl[19]) else $error("a_r3_outer_off_in_seq");

  // R8: done is a single-cycle pulse
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("a_r8_done_one_cycle");

  // R8: done comes with the end of busy and the outer bypass back on
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy) && pllCtl[19])) else $error("a_r8_done_ends_busy");

  // R11: the upper word cannot change once a sequence is under way
  a_r11_hi_held_in_seq: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> $stable(pllHi)) else $error("a_r11_hi_held_in_seq");

  // R12: no change of the control word without a write strobe
  a_r12_ctl_stable: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrStb |-> $stable(pllCtl)) else $error("a_r12_ctl_stable");

  // R1: outputs idle straight out of reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!busy && !done)) else $error("a_r1_reset_idle");

  // helper so the start port is used even when not referenced above in some builds
  logic unusedStart;
  assign unusedStart = startReq;

endmodule

bind pll_bringup_seq pll_bringup_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .pllCtl(pllCtl), .pllHi(pllHi),
  .ctlWrStb(ctlWrStb), .busy(busy), .done(done)
);

// File: tb/pll_bringup_seq_bench.sv
`timescale 1ns/1ps
module pll_bringup_seq_bench;

  localparam int WAIT  = 6;
  localparam int DIM_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic [DIM_W-1:0] hAct = '0;
  logic [DIM_W-1:0] vAct = '0;
  logic [31:0]      pllCtl, pllHi;
  logic             ctlWrStb, busy, done;

  int checks = 0;
  int fails  = 0;
  logic [31:0] prevCtl;

  always #4 clk = ~clk;

  pll_bringup_seq #(.DIM_W(DIM_W), .WAIT_CYC(WAIT)) u_pll_bringup_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .hActive(hAct), .vActive(vAct),
    .pllCtl(pllCtl), .pllHi(pllHi), .ctlWrStb(ctlWrStb), .busy(busy), .done(done)
  );

  int tH [13] = '{640, 800, 1024, 1152, 1280, 1280, 1280, 1280, 1440, 1600, 1600, 1920, 1920};
  int tV [13] = '{480, 600, 768, 864, 768, 720, 960, 1024, 900, 900, 1200, 1080, 1200};
  int tM [13] = '{25, 40, 65, 160, 80, 74, 108, 108, 106, 108, 162, 148, 193};
  int tN [13] = '{1, 1, 1, 2, 1, 1, 1, 1, 1, 1, 1, 1, 1};

  function automatic logic [31:0] expLo(int m, int n);
    return 32'h0006_0000 | (32'(n) << 8) | 32'(m);
  endfunction

  function automatic logic [31:0] expHi(int m, int n);
    return 32'hA500_0000 | 32'(m / n);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // stable window: n cycles with no write, word held, still busy (R12)
  task automatic holdCheck(int n, logic [31:0] word);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R12 word held", pllCtl, word);
      chk("R12 no strobe", 32'(ctlWrStb), 32'd0);
      chk("R11 busy held", 32'(busy), 32'd1);
    end
  endtask

  task automatic runSeq(int h, int v, int m, int n, bit inject);
    logic [31:0] lo, hi, w;
    lo = expLo(m, n);
    hi = expHi(m, n);
    hAct = DIM_W'(h);
    vAct = DIM_W'(v);
    startReq = 1'b1;
    @(posedge clk);                       // E0
    @(negedge clk);
    startReq = 1'b0;
    chk("R2 hi loaded", pllHi, hi);
    chk("R2 busy", 32'(busy), 32'd1);
    chk("R2 ctl untouched", pllCtl, prevCtl);
    @(negedge clk);                       // after E0+1
    w = prevCtl & ~32'h0008_0000;
    chk("R3 outer cleared", pllCtl, w);
    chk("R12 strobe", 32'(ctlWrStb), 32'd1);
    @(negedge clk);                       // after E0+2
    chk("R4 arm word", pllCtl, 32'h0006_0000);
    @(negedge clk);                       // after E0+3
    chk("R5 config word", pllCtl, lo);
    chk("R9 R10 config word", pllCtl, lo);
    if (inject) begin
      @(negedge clk);
      hAct = DIM_W'(1920);
      vAct = DIM_W'(1200);
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      chk("R11 ctl unchanged", pllCtl, lo);
      chk("R11 hi unchanged", pllHi, hi);
      holdCheck(WAIT - 3, lo);
    end else begin
      holdCheck(WAIT - 1, lo);
    end
    @(negedge clk);                       // after E0+3+W
    w = lo & ~32'h0002_0000;
    chk("R6 power off", pllCtl, w);
    chk("R12 strobe", 32'(ctlWrStb), 32'd1);
    holdCheck(WAIT - 1, w);
    @(negedge clk);                       // after E0+3+2W
    w = w & ~32'h0004_0000;
    chk("R7 inner off", pllCtl, w);
    holdCheck(WAIT - 1, w);
    @(negedge clk);                       // after E0+3+3W
    w = w | 32'h0008_0000;
    chk("R8 outer on", pllCtl, w);
    chk("R8 done", 32'(done), 32'd1);
    chk("R8 busy low", 32'(busy), 32'd0);
    chk("R11 hi final", pllHi, hi);
    @(negedge clk);
    chk("R8 done pulse", 32'(done), 32'd0);
    chk("R12 held after end", pllCtl, w);
    prevCtl = w;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog R8 act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctl reset", pllCtl, 32'h0008_0119);
    chk("R1 hi reset", pllHi, 32'hA500_0019);
    chk("R1 busy reset", 32'(busy), 32'd0);
    chk("R1 done reset", 32'(done), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 ctl after reset", pllCtl, 32'h0008_0119);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    prevCtl = 32'h0008_0119;

    // R9: every table mode
    for (int i = 0; i < 13; i++) begin
      runSeq(tH[i], tV[i], tM[i], tN[i], 1'b0);
      @(negedge clk);
    end

    // R10: pairs that miss the table fall back to 25 MHz
    runSeq(640, 600, 25, 1, 1'b0);
    runSeq(1080, 1920, 25, 1, 1'b0);
    runSeq(0, 0, 25, 1, 1'b0);
    runSeq(1921, 1200, 25, 1, 1'b0);

    // R11: a second request mid-sequence is dropped
    runSeq(800, 600, 40, 1, 1'b1);
    @(negedge clk);
    chk("R11 idle after ignored start", 32'(busy), 32'd0);
    runSeq(1280, 720, 74, 1, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule